// File: doc/BRIEF.md
# Reconfigurable Three-Term Dot-Product Unit

This unit executes one instruction: the dot product of two three-element signed vectors, the sum of the three pairwise products. A 3-bit schedule code, sampled with the start strobe, picks how the work is spread over a small pool of arithmetic resources. There are three multipliers, a 3-input adder, a 2-input adder with a partial-sum register, and a fused single-step dot-product block. Each schedule gives the same answer. They differ in cycle count and in how many multipliers switch at once, so the caller can trade latency against peak activity at run time.

A caller pulses `start_i` for one cycle while the unit is idle, with the code and all six operands valid on the same cycle. The unit copies them into its own registers, so the operand pins may change on the next cycle. `done_o` drops on the cycle after acceptance and rises once `dot_o` holds the finished sum. It then stays high, with `dot_o` frozen, until the next accepted start. `start_i` and `done_o` are plain control pins. There is no back-pressure: a start pulse while busy is dropped, and the caller must wait for `done_o` before issuing again. `mul_active_o` reports in every cycle how many multipliers are working.

Top module: `vecdot_unit`

## Requirements
- R1: When `done_o` is 1, `dot_o` equals a0*b0 + a1*b1 + a2*b2, computed from the operands captured at acceptance. This holds for every schedule code.
- R2: After reset, `done_o` is 0, `dot_o` is 0 and `mul_active_o` is 0.
- R3: Latency is counted in rising clock edges, from the edge that samples the start pulse to the edge after which `done_o` reads 1. It is 2 for code 3'b111, 1 for 3'b000, 4 for 3'b001, 3 for 3'b011 and 4 for 3'b101.
- R4: The maximum of `mul_active_o` during an operation is 3 for code 3'b111, 0 for 3'b000 (the fused block uses no multiplier), 1 for 3'b001, 2 for 3'b011 and 1 for 3'b101. `mul_active_o` is 0 whenever the unit is idle.
- R5: Codes 3'b010, 3'b100 and 3'b110 behave exactly as 3'b001, with the same latency and the same peak activity.
- R6: A start pulse while busy is ignored, and operand or code changes after acceptance have no effect. The running operation finishes with its original latency and result.
- R7: `done_o` reads 0 in the cycle after an accepted start. Once set, `done_o` and `dot_o` hold their values until the next accepted start.
- R8: With every operand at -32768, the result is exactly 3221225472. The result width is 2*OP_W+2 bits, so no sum overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start strobe, accepted only while idle |
| mode_i | input | 3 | Schedule code, sampled with the start strobe |
| a0_i | input | OP_W | First vector, element 0, signed |
| a1_i | input | OP_W | First vector, element 1, signed |
| a2_i | input | OP_W | First vector, element 2, signed |
| b0_i | input | OP_W | Second vector, element 0, signed |
| b1_i | input | OP_W | Second vector, element 1, signed |
| b2_i | input | OP_W | Second vector, element 2, signed |
| dot_o | output | 2*OP_W+2 | Signed dot product, valid while done_o is 1 |
| done_o | output | 1 | Result-complete flag |
| mul_active_o | output | 2 | Number of multipliers working in the current cycle |

## Verification
The bench builds the unit with the default OP_W of 16, which makes -32768 the most negative operand. Because the result width follows OP_W, this brings the worst-case positive and negative sums of three full-scale products within reach, so the no-overflow margin is tested exactly. At this width every schedule, including the undefined codes and a start pulse landing mid-operation, is exercised against an independently computed reference sum, latency and peak multiplier count.

// File: rtl/vecdot_pkg.sv
package vecdot_pkg;

  localparam int NUM_MUL = 3;
  localparam int STEP_W  = 2;

  localparam logic [2:0] CODE_FUSED  = 3'b000;
  localparam logic [2:0] CODE_SERIAL = 3'b001;
  localparam logic [2:0] CODE_PAIR   = 3'b011;
  localparam logic [2:0] CODE_REUSE  = 3'b101;
  localparam logic [2:0] CODE_WIDE   = 3'b111;

  typedef enum logic [2:0] {
    SCH_FUSED, SCH_WIDE, SCH_SERIAL, SCH_PAIR, SCH_REUSE
  } sched_e;

  typedef enum logic [2:0] {
    ADD_NONE, ADD_ALL3, ADD_HEAD, ADD_TAIL, ADD_FUSED
  } add_op_e;

  typedef struct packed {
    logic [NUM_MUL-1:0]       mul_en;
    logic [NUM_MUL-1:0][1:0]  mul_sel;
    add_op_e                  add_op;
    logic                     last;
  } step_ctl_t;

  function automatic sched_e decode_code(logic [2:0] code);
    case (code)
      CODE_FUSED: return SCH_FUSED;
      CODE_WIDE:  return SCH_WIDE;
      CODE_PAIR:  return SCH_PAIR;
      CODE_REUSE: return SCH_REUSE;
      default:    return SCH_SERIAL;
    endcase
  endfunction

  function automatic int unsigned sched_latency(sched_e s);
    case (s)
      SCH_FUSED: return 1;
      SCH_WIDE:  return 2;
      SCH_PAIR:  return 3;
      default:   return 4;
    endcase
  endfunction

  // Control word for one step of one schedule.
  function automatic step_ctl_t step_plan(sched_e s, logic [STEP_W-1:0] step);
    step_ctl_t c;
    c = '0;
    c.add_op = ADD_NONE;
    case (s)
      SCH_FUSED: begin
        c.add_op = ADD_FUSED;
        c.last   = 1'b1;
      end
      SCH_WIDE: begin
        if (step == 2'd0) begin
          c.mul_en     = 3'b111;
          c.mul_sel[0] = 2'd0;
          c.mul_sel[1] = 2'd1;
          c.mul_sel[2] = 2'd2;
        end else begin
          c.add_op = ADD_ALL3;
          c.last   = 1'b1;
        end
      end
      SCH_PAIR: begin
        case (step)
          2'd0: begin
            c.mul_en     = 3'b011;
            c.mul_sel[0] = 2'd0;
            c.mul_sel[1] = 2'd1;
          end
          2'd1: begin
            c.mul_en     = 3'b001;
            c.mul_sel[0] = 2'd2;
            c.add_op     = ADD_HEAD;
          end
          default: begin
            c.add_op = ADD_TAIL;
            c.last   = 1'b1;
          end
        endcase
      end
      SCH_REUSE: begin
        if (step == 2'd3) begin
          c.add_op = ADD_TAIL;
          c.last   = 1'b1;
        end else begin
          c.mul_en     = 3'b001;
          c.mul_sel[0] = step;
          if (step == 2'd2) c.add_op = ADD_HEAD;
        end
      end
      default: begin
        if (step == 2'd3) begin
          c.add_op = ADD_ALL3;
          c.last   = 1'b1;
        end else begin
          c.mul_en     = 3'b001;
          c.mul_sel[0] = step;
        end
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/vecdot_mul.sv
module vecdot_mul #(
  parameter int OP_W = 16,
  localparam int PR_W = 2 * OP_W
) (
  input  logic signed [OP_W-1:0] x_i,
  input  logic signed [OP_W-1:0] y_i,
  output logic signed [PR_W-1:0] p_o
);
  always_comb p_o = PR_W'(x_i) * PR_W'(y_i);
endmodule

// File: rtl/vecdot_fused.sv
module vecdot_fused #(
  parameter int OP_W = 16,
  localparam int RES_W = 2 * OP_W + 2
) (
  input  logic [2:0][OP_W-1:0]  a_i,
  input  logic [2:0][OP_W-1:0]  b_i,
  output logic signed [RES_W-1:0] sum_o
);
  always_comb begin
    sum_o = '0;
    for (int i = 0; i < 3; i++) begin
      sum_o = sum_o + RES_W'($signed(a_i[i])) * RES_W'($signed(b_i[i]));
    end
  end
endmodule

// File: rtl/vecdot_sched.sv
module vecdot_sched
  import vecdot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [2:0] mode_i,
  output logic       accept_o,
  output logic       busy_o,
  output sched_e     sched_o,
  output step_ctl_t  ctl_o
);
  logic [STEP_W-1:0] step_q;

  assign accept_o = start_i && !busy_o;

  always_comb begin
    if (busy_o) ctl_o = step_plan(sched_o, step_q);
    else begin
      ctl_o = '0;
      ctl_o.add_op = ADD_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o  <= 1'b0;
      step_q  <= '0;
      sched_o <= SCH_SERIAL;
    end else if (accept_o) begin
      busy_o  <= 1'b1;
      step_q  <= '0;
      sched_o <= decode_code(mode_i);
    end else if (busy_o) begin
      step_q <= step_q + 2'd1;
      if (ctl_o.last) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/vecdot_datapath.sv
module vecdot_datapath
  import vecdot_pkg::*;
#(
  parameter int OP_W = 16,
  localparam int PR_W  = 2 * OP_W,
  localparam int RES_W = 2 * OP_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept_i,
  input  logic [2:0][OP_W-1:0]    a_i,
  input  logic [2:0][OP_W-1:0]    b_i,
  input  step_ctl_t               ctl_i,
  output logic signed [RES_W-1:0] res_o
);
  logic [2:0][OP_W-1:0]         a_q, b_q;
  logic [NUM_MUL-1:0][OP_W-1:0] mx, my;
  logic signed [PR_W-1:0]       mp [NUM_MUL];
  logic signed [PR_W-1:0]       prod_q [3];
  logic signed [RES_W-1:0]      part_q, fused_sum, sum3, tail;

  for (genvar k = 0; k < NUM_MUL; k++) begin : g_mul
    always_comb begin
      mx[k] = '0;
      my[k] = '0;
      if (ctl_i.mul_sel[k] < 2'd3) begin
        mx[k] = a_q[ctl_i.mul_sel[k]];
        my[k] = b_q[ctl_i.mul_sel[k]];
      end
    end
    vecdot_mul #(.OP_W(OP_W)) u_mul (
      .x_i($signed(mx[k])), .y_i($signed(my[k])), .p_o(mp[k])
    );
  end

  vecdot_fused #(.OP_W(OP_W)) u_fused (.a_i(a_q), .b_i(b_q), .sum_o(fused_sum));

  always_comb begin
    sum3 = RES_W'(prod_q[0]) + RES_W'(prod_q[1]) + RES_W'(prod_q[2]);
    tail = part_q + RES_W'(prod_q[2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      part_q <= '0;
      res_o  <= '0;
      for (int j = 0; j < 3; j++) prod_q[j] <= '0;
    end else begin
      if (accept_i) begin
        a_q <= a_i;
        b_q <= b_i;
      end
      for (int j = 0; j < 3; j++) begin
        for (int k = 0; k < NUM_MUL; k++) begin
          if (ctl_i.mul_en[k] && ctl_i.mul_sel[k] == 2'(j)) prod_q[j] <= mp[k];
        end
      end
      case (ctl_i.add_op)
        ADD_ALL3:  res_o  <= sum3;
        ADD_HEAD:  part_q <= RES_W'(prod_q[0]) + RES_W'(prod_q[1]);
        ADD_TAIL:  res_o  <= tail;
        ADD_FUSED: res_o  <= fused_sum;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vecdot_unit.sv
module vecdot_unit
  import vecdot_pkg::*;
#(
  parameter int OP_W = 16,
  localparam int RES_W = 2 * OP_W + 2,
  localparam int ACT_W = $clog2(NUM_MUL + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [2:0]              mode_i,
  input  logic [OP_W-1:0]         a0_i,
  input  logic [OP_W-1:0]         a1_i,
  input  logic [OP_W-1:0]         a2_i,
  input  logic [OP_W-1:0]         b0_i,
  input  logic [OP_W-1:0]         b1_i,
  input  logic [OP_W-1:0]         b2_i,
  output logic [RES_W-1:0]        dot_o,
  output logic                    done_o,
  output logic [ACT_W-1:0]        mul_active_o
);
  logic      accept, busy;
  sched_e    sched_q;
  step_ctl_t ctl;
  logic signed [RES_W-1:0] res;

  vecdot_sched u_sched (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .accept_o(accept), .busy_o(busy), .sched_o(sched_q), .ctl_o(ctl)
  );

  vecdot_datapath #(.OP_W(OP_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept_i(accept),
    .a_i({a2_i, a1_i, a0_i}), .b_i({b2_i, b1_i, b0_i}),
    .ctl_i(ctl), .res_o(res)
  );

  assign dot_o = res;

  always_comb begin
    mul_active_o = '0;
    for (int k = 0; k < NUM_MUL; k++) mul_active_o = mul_active_o + ACT_W'(ctl.mul_en[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_o <= 1'b0;
    else if (accept)   done_o <= 1'b0;
    else if (ctl.last) done_o <= 1'b1;
  end
endmodule

// File: rtl/vecdot_checker.sv
module vecdot_checker
  import vecdot_pkg::*;
#(
  parameter int RES_W = 34,
  parameter int ACT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy,
  input sched_e           sched_q,
  input logic             done_o,
  input logic [RES_W-1:0] dot_o,
  input logic [ACT_W-1:0] mul_active_o
);
  logic [2:0] lat_cnt;
  logic [ACT_W-1:0] peak_lim;

  always_comb begin
    case (sched_q)
      SCH_WIDE:  peak_lim = ACT_W'(3);
      SCH_PAIR:  peak_lim = ACT_W'(2);
      SCH_FUSED: peak_lim = ACT_W'(0);
      default:   peak_lim = ACT_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lat_cnt <= '0;
    else if (start_i && !busy) lat_cnt <= '0;
    else if (busy)             lat_cnt <= lat_cnt + 3'd1;
  end

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (lat_cnt == 3'(sched_latency(sched_q))));

  a_r4_peak_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mul_active_o <= peak_lim));

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mul_active_o == '0));

  a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy) |=> !done_o);

  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(dot_o)));

  a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> $stable(sched_q));

  a_r1_done_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy);
endmodule

bind vecdot_unit vecdot_checker #(.RES_W(RES_W), .ACT_W(ACT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy(busy), .sched_q(sched_q),
  .done_o(done_o), .dot_o(dot_o), .mul_active_o(mul_active_o)
);

// File: tb/tb_vecdot_unit.sv
module tb_vecdot_unit;
  localparam int OP_W  = 16;
  localparam int RES_W = 2 * OP_W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] mode_i = 3'b000;
  logic [OP_W-1:0] a0_i = '0, a1_i = '0, a2_i = '0, b0_i = '0, b1_i = '0, b2_i = '0;
  logic [RES_W-1:0] dot_o;
  logic done_o;
  logic [1:0] mul_active_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vecdot_unit #(.OP_W(OP_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .a0_i(a0_i), .a1_i(a1_i), .a2_i(a2_i), .b0_i(b0_i), .b1_i(b1_i), .b2_i(b2_i),
    .dot_o(dot_o), .done_o(done_o), .mul_active_o(mul_active_o)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_lat(logic [2:0] m);
    case (m)
      3'b111: return 2;
      3'b000: return 1;
      3'b011: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic int exp_peak(logic [2:0] m);
    case (m)
      3'b111: return 3;
      3'b000: return 0;
      3'b011: return 2;
      default: return 1;
    endcase
  endfunction

  // Issue one operation, optionally with a spurious start at cycle index spur.
  task automatic run_op(logic [2:0] m, int x0, int x1, int x2, int y0, int y1, int y2,
                        string req, int spur);
    longint expv;
    int idx, peak;
    expv = longint'(x0) * y0 + longint'(x1) * y1 + longint'(x2) * y2;
    @(negedge clk);
    start_i = 1'b1; mode_i = m;
    a0_i = OP_W'(x0); a1_i = OP_W'(x1); a2_i = OP_W'(x2);
    b0_i = OP_W'(y0); b1_i = OP_W'(y1); b2_i = OP_W'(y2);
    @(negedge clk);
    start_i = 1'b0; mode_i = ~m;
    a0_i = 16'h1234; a1_i = 16'h7777; a2_i = 16'h8001;
    b0_i = 16'h0F0F; b1_i = 16'hFFFF; b2_i = 16'h2222;
    check(done_o == 1'b0, "R7 done cleared after accept", longint'(done_o), 0);
    idx = 0; peak = 0;
    while (!done_o && idx < 12) begin
      if (int'(mul_active_o) > peak) peak = int'(mul_active_o);
      if (idx == spur) begin
        start_i = 1'b1; mode_i = 3'b111;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      idx++;
    end
    start_i = 1'b0;
    check(idx == exp_lat(m), {req, " latency (R3)"}, idx, exp_lat(m));
    check(peak == exp_peak(m), {req, " peak multipliers (R4)"}, peak, exp_peak(m));
    check(longint'($signed(dot_o)) == expv, {req, " result (R1)"},
          longint'($signed(dot_o)), expv);
  endtask

  task automatic t_reset();
    check(done_o == 1'b0, "R2 done at reset", longint'(done_o), 0);
    check(dot_o == '0, "R2 result at reset", longint'(dot_o), 0);
    check(mul_active_o == 2'd0, "R2 activity at reset", longint'(mul_active_o), 0);
  endtask

  task automatic t_modes();
    run_op(3'b111, 3, -4, 5, 7, 2, -6, "R1 wide", -1);
    run_op(3'b000, 100, 200, -300, -1, 2, 3, "R1 fused", -1);
    run_op(3'b001, -9, 8, 7, 6, -5, 4, "R1 serial", -1);
    run_op(3'b011, 1000, -2000, 3000, 11, 12, -13, "R1 pair", -1);
    run_op(3'b101, 32767, -1, 0, 2, 32767, 555, "R1 reuse", -1);
    run_op(3'b111, 0, 0, 0, 123, -456, 789, "R1 wide zeros", -1);
  endtask

  task automatic t_idle_quiet();
    repeat (3) @(negedge clk);
    check(mul_active_o == 2'd0, "R4 idle activity", longint'(mul_active_o), 0);
  endtask

  task automatic t_undefined();
    run_op(3'b010, 5, 6, 7, 8, 9, 10, "R5 code 010", -1);
    run_op(3'b100, -5, 6, -7, 8, -9, 10, "R5 code 100", -1);
    run_op(3'b110, 12, 0, -1, -1, 4, 4, "R5 code 110", -1);
  endtask

  task automatic t_busy_start();
    run_op(3'b001, 21, 22, 23, -1, -2, -3, "R6 start while busy", 1);
    run_op(3'b101, -300, 40, 7, 9, 9, -9, "R6 late start while busy", 2);
  endtask

  task automatic t_hold();
    logic [RES_W-1:0] held;
    run_op(3'b011, 77, -88, 99, 3, 3, 3, "R7 base", -1);
    held = dot_o;
    a0_i = 16'h5555; mode_i = 3'b000;
    repeat (4) @(negedge clk);
    check(done_o == 1'b1, "R7 done held", longint'(done_o), 1);
    check(dot_o == held, "R7 result held", longint'(dot_o), longint'(held));
  endtask

  task automatic t_extremes();
    run_op(3'b111, -32768, -32768, -32768, -32768, -32768, -32768, "R8 max pos", -1);
    check(longint'($signed(dot_o)) == 64'sd3221225472, "R8 exact sum",
          longint'($signed(dot_o)), 64'sd3221225472);
    run_op(3'b001, -32768, -32768, -32768, 32767, 32767, 32767, "R8 max neg", -1);
    run_op(3'b000, -32768, 32767, -32768, -32768, 32767, -32768, "R8 fused full", -1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_modes();
    t_idle_quiet();
    t_undefined();
    t_busy_start();
    t_hold();
    t_extremes();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule